// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block gathers 32 peripheral interrupt lines and five system exceptions. It keeps one pending bit for each source and an enable bit for each peripheral line. Each cycle it picks the most urgent source that is pending, enabled and not masked. It presents that source's exception number and its word-aligned vector-table address to the core.

Two system exceptions have fixed priority: NMI and HardFault. They outrank every programmable level. The supervisor call, the deferred-service request, the system tick and every peripheral line carry a 2-bit programmable priority. A register-style write port sets and clears enables, loads priority fields and sets two global masks: a block-all bit and a base-priority threshold.

The offer to the core is a valid/ready stream. `out_valid` is high while a winner exists whose level is strictly more urgent than the level of the handler now running. A transfer happens on a clock edge where `out_valid` and `out_ready` are both high. The transfer clears that source's pending bit and makes its level the active level. While `out_ready` is low the offer may change. A more urgent source can replace it. A write to the enables, the priorities or the masks can also withdraw it. The core therefore samples the payload only in the cycle it accepts. `handler_done` is a plain pulse that returns the active level to idle.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Peripheral line i is exception number 16+i. NMI is 2, HardFault 3, supervisor call 11, deferred service 14 and system tick 15. `out_vector` equals the exception number times 4, so line 0 gives 0x40, line 31 gives 0xBC and NMI gives 0x08.
- R2: A write to address 0 sets the enable of every line whose data bit is 1. Data bits that are 0 leave their enables unchanged.
- R3: A write to address 1 clears the enable of every line whose data bit is 1. Data bits that are 0 leave their enables unchanged.
- R4: A one-cycle request pulse latches the pending bit even while the line is disabled. Enabling the line later produces an offer. Disabling a line hides its offer but keeps it pending.
- R5: The lower priority value wins. NMI beats HardFault, and HardFault beats every programmable level. Between equal levels, the lower exception number wins.
- R6: Bit 0 of the mask word (address 3) blocks every programmable-priority source. NMI and HardFault are still offered.
- R7: Bits [9:8] of the mask word form a threshold. When the threshold is nonzero, it blocks every programmable source whose priority value is greater than or equal to it. NMI and HardFault are never blocked.
- R8: A transfer clears the accepted source's pending bit. If a request for the same source arrives in the same cycle, that request sets the bit again.
- R9: `out_valid` is high only when the winner's level is strictly more urgent than the active level. A transfer makes the winner's level active. `handler_done` returns the active level to idle, after which any winner is offered.
- R10: After reset, all enables are 0, all priorities are 0, both masks are off, nothing is pending and `out_valid` is low.
- R11: Address 2 holds the system priorities: supervisor call in bits [1:0], deferred service in [3:2] and system tick in [5:4]. Address 4+k holds the priorities of lines 16k to 16k+15, with line 16k+j in bits [2j+1:2j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 32 | Peripheral request pulses, bit i for line i |
| nmi_req | input | 1 | NMI request pulse |
| hardfault_req | input | 1 | HardFault request pulse |
| svcall_req | input | 1 | Supervisor call request pulse |
| pendsv_req | input | 1 | Deferred-service request pulse |
| systick_req | input | 1 | System tick request pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| out_valid | output | 1 | A winner is offered to the core |
| out_ready | input | 1 | The core accepts the offer |
| out_exc | output | 6 | Exception number of the offer |
| out_vector | output | 8 | Vector-table byte address of the offer |
| handler_done | input | 1 | The running handler has completed |

## Verification
The bench aims at ties between equal levels, including two lines whose priorities sit in different priority words. A design that broke ties by scan order from the top, or read the wrong word, would offer the higher exception number. It writes all-zero data to both enable views and masks a pending but disabled line. A design that wrote the enables directly would lose enables, and one that gated the pending latch with the enable would drop the request. It re-requests a line in the same cycle as its acceptance, and raises a request equal in level to the active one. A wrong design would then either lose the request or let an equal-level source preempt. It sweeps the threshold across a level and checks NMI under both masks, where an off-by-one comparison or a mask applied to the fixed levels shows up as a wrong or missing offer.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SYS      = 5;   // NMI, HardFault, SVC, deferred service, tick
  localparam int IRQ_BASE_EXC = 16;
  localparam int CFG_AW       = 4;
  localparam int MASK_TH_LSB  = 8;

  typedef enum logic [CFG_AW-1:0] {
    CFG_SETENA  = 4'd0,
    CFG_CLRENA  = 4'd1,
    CFG_SYSPRI  = 4'd2,
    CFG_MASK    = 4'd3,
    CFG_IRQPRI0 = 4'd4
  } cfg_addr_e;

  // source index -> exception number; sources ordered by exception number
  function automatic logic [7:0] exc_of(input int s);
    case (s)
      0:       exc_of = 8'd2;
      1:       exc_of = 8'd3;
      2:       exc_of = 8'd11;
      3:       exc_of = 8'd14;
      4:       exc_of = 8'd15;
      default: exc_of = 8'(s - NUM_SYS + IRQ_BASE_EXC);
    endcase
  endfunction
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [31:0]               cfg_wdata,
  output logic [NUM_IRQ-1:0]        irq_en,
  output logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  output logic [3*PRIO_W-1:0]       sys_prio,
  output logic                      primask,
  output logic [PRIO_W-1:0]         basepri
);
  localparam int FPW = 32 / PRIO_W;

  logic wr_set, wr_clr;
  assign wr_set = cfg_we && (cfg_addr == CFG_SETENA);
  assign wr_clr = cfg_we && (cfg_addr == CFG_CLRENA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en   <= '0;
      irq_prio <= '0;
      sys_prio <= '0;
      primask  <= 1'b0;
      basepri  <= '0;
    end else begin
      if (wr_set) irq_en <= irq_en | cfg_wdata[NUM_IRQ-1:0];
      else if (wr_clr) irq_en <= irq_en & ~cfg_wdata[NUM_IRQ-1:0];
      if (cfg_we && cfg_addr == CFG_SYSPRI) sys_prio <= cfg_wdata[3*PRIO_W-1:0];
      if (cfg_we && cfg_addr == CFG_MASK) begin
        primask <= cfg_wdata[0];
        basepri <= cfg_wdata[MASK_TH_LSB +: PRIO_W];
      end
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (cfg_we && int'(cfg_addr) == int'(CFG_IRQPRI0) + i / FPW)
          irq_prio[i*PRIO_W +: PRIO_W] <= cfg_wdata[(i % FPW)*PRIO_W +: PRIO_W];
      end
    end
  end

  assert_setena_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((irq_en & $past(cfg_wdata[NUM_IRQ-1:0])) == $past(cfg_wdata[NUM_IRQ-1:0])));

  assert_clrena_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((irq_en & $past(cfg_wdata[NUM_IRQ-1:0])) == '0));

  assert_zero_bits_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set || wr_clr) |=> (((irq_en ^ $past(irq_en)) & ~$past(cfg_wdata[NUM_IRQ-1:0])) == '0));
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int W = 37
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_req,
  input  logic [W-1:0] clr_req,
  output logic [W-1:0] pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_req) | set_req;
  end

  assert_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req != '0) |=> ((pend & $past(set_req)) == $past(set_req)));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req != '0) |=> ((pend & $past(clr_req & ~set_req)) == '0));
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int NSRC  = 37,
  parameter int LVL_W = 3,
  parameter int IDX_W = 6
) (
  input  logic [NSRC-1:0]       elig,
  input  logic [NSRC*LVL_W-1:0] lvl,
  output logic                  found,
  output logic [IDX_W-1:0]      win_idx,
  output logic [LVL_W-1:0]      win_lvl
);
  // ascending scan with strict compare: equal levels keep the lower index
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '1;
    for (int s = 0; s < NSRC; s++) begin
      if (elig[s] && (!found || lvl[s*LVL_W +: LVL_W] < win_lvl)) begin
        found   = 1'b1;
        win_idx = IDX_W'(s);
        win_lvl = lvl[s*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import intc_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         irq_req,
  input  logic                       nmi_req,
  input  logic                       hardfault_req,
  input  logic                       svcall_req,
  input  logic                       pendsv_req,
  input  logic                       systick_req,
  input  logic                       cfg_we,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [31:0]                cfg_wdata,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [$clog2(IRQ_BASE_EXC+NUM_IRQ)-1:0]   out_exc,
  output logic [$clog2(IRQ_BASE_EXC+NUM_IRQ)+1:0]   out_vector,
  input  logic                       handler_done
);
  localparam int NSRC  = NUM_SYS + NUM_IRQ;
  localparam int EXC_W = $clog2(IRQ_BASE_EXC + NUM_IRQ);
  localparam int IDX_W = $clog2(NSRC);
  localparam int LVL_W = PRIO_W + 1;   // fixed levels 0,1; programmable p+2
  localparam logic [LVL_W-1:0] LVL_IDLE = '1;

  logic [NUM_IRQ-1:0]        irq_en;
  logic [NUM_IRQ*PRIO_W-1:0] irq_prio;
  logic [3*PRIO_W-1:0]       sys_prio;
  logic                      primask;
  logic [PRIO_W-1:0]         basepri;

  intc_cfg_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .irq_en(irq_en), .irq_prio(irq_prio),
    .sys_prio(sys_prio), .primask(primask), .basepri(basepri)
  );

  logic [NSRC-1:0] set_req, clr_req, pend;
  assign set_req = {irq_req, systick_req, pendsv_req, svcall_req, hardfault_req, nmi_req};

  intc_pending #(.W(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req), .pend(pend)
  );

  function automatic logic blocked(input logic [PRIO_W-1:0] p, input logic pm,
                                   input logic [PRIO_W-1:0] th);
    return pm || ((th != '0) && (p >= th));
  endfunction

  logic [NSRC-1:0]       elig;
  logic [NSRC*LVL_W-1:0] lvl;

  for (genvar f = 0; f < 2; f++) begin : g_fixed
    assign elig[f]                = pend[f];
    assign lvl[f*LVL_W +: LVL_W] = LVL_W'(f);
  end

  for (genvar k = 0; k < 3; k++) begin : g_sys
    logic [PRIO_W-1:0] p;
    assign p = sys_prio[k*PRIO_W +: PRIO_W];
    assign elig[2+k] = pend[2+k] && !blocked(p, primask, basepri);
    assign lvl[(2+k)*LVL_W +: LVL_W] = LVL_W'(p) + LVL_W'(2);
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic [PRIO_W-1:0] p;
    assign p = irq_prio[i*PRIO_W +: PRIO_W];
    assign elig[NUM_SYS+i] = pend[NUM_SYS+i] && irq_en[i] && !blocked(p, primask, basepri);
    assign lvl[(NUM_SYS+i)*LVL_W +: LVL_W] = LVL_W'(p) + LVL_W'(2);
  end

  logic             found;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;

  intc_pick #(.NSRC(NSRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pick (
    .elig(elig), .lvl(lvl), .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  logic [LVL_W-1:0] active_lvl;
  logic             accept;

  assign out_valid  = found && (win_lvl < active_lvl);
  assign accept     = out_valid && out_ready;
  assign out_exc    = EXC_W'(exc_of(int'(win_idx)));
  assign out_vector = {out_exc, 2'b00};
  assign clr_req    = accept ? (NSRC'(1) << win_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            active_lvl <= LVL_IDLE;
    else if (accept)       active_lvl <= win_lvl;
    else if (handler_done) active_lvl <= LVL_IDLE;
  end

  assert_winner_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> elig[win_idx]);

  assert_primask_fixed_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && primask) |-> (out_exc <= EXC_W'(3)));

  assert_threshold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && basepri != '0) |-> (win_lvl < LVL_W'(basepri) + LVL_W'(2)));

  assert_no_reoffer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !(out_valid && out_exc == $past(out_exc)));

  assert_done_reopens_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_done && !accept) |=> (out_valid || !found));
endmodule

// File: tb/irq_prio_arbiter_test.sv
module irq_prio_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {line a[5], prio a[2], line b[5], prio b[2], expected exception[6]}
  localparam logic [19:0] VECS [NVEC] = '{
    {5'd3,  2'd2, 5'd7,  2'd1, 6'd23},
    {5'd3,  2'd1, 5'd7,  2'd1, 6'd19},
    {5'd31, 2'd0, 5'd0,  2'd3, 6'd47},
    {5'd0,  2'd0, 5'd31, 2'd0, 6'd16},
    {5'd10, 2'd3, 5'd20, 2'd2, 6'd36},
    {5'd15, 2'd1, 5'd16, 2'd1, 6'd31}
  };

  logic clk = 0, rst_n = 0;
  logic [31:0] irq_req = '0;
  logic nmi_req = 0, hardfault_req = 0, svcall_req = 0, pendsv_req = 0, systick_req = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic out_valid, out_ready = 0, handler_done = 0;
  logic [5:0] out_exc;
  logic [7:0] out_vector;
  int n_checks = 0, n_fail = 0;

  irq_prio_arbiter uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
    .hardfault_req(hardfault_req), .svcall_req(svcall_req), .pendsv_req(pendsv_req),
    .systick_req(systick_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_exc(out_exc), .out_vector(out_vector), .handler_done(handler_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1;
  endtask

  task automatic cfg(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; step(); cfg_we = 0;
  endtask

  // sys bits: 0 NMI, 1 HardFault, 2 supervisor call, 3 deferred service, 4 tick
  task automatic pulse(input logic [31:0] irqs, input logic [4:0] sys);
    irq_req = irqs;
    {systick_req, pendsv_req, svcall_req, hardfault_req, nmi_req} = sys;
    step();
    irq_req = '0;
    {systick_req, pendsv_req, svcall_req, hardfault_req, nmi_req} = '0;
  endtask

  task automatic take();
    out_ready = 1; step(); out_ready = 0;
  endtask

  task automatic done();
    handler_done = 1; step(); handler_done = 0;
  endtask

  task automatic take_done();
    take(); done();
  endtask

  task automatic check(input string tag, input logic exp_v, input int exp_exc);
    n_checks++;
    if (out_valid !== exp_v ||
        (exp_v && (out_exc !== 6'(exp_exc) || out_vector !== 8'(exp_exc * 4)))) begin
      n_fail++;
      $display("FAIL %s: valid=%0b exc=%0d vec=0x%0h expected valid=%0b exc=%0d vec=0x%0h",
               tag, out_valid, out_exc, out_vector, exp_v, exp_exc, exp_exc * 4);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    // table: two enabled lines, priority order, ties and vector addresses (R1 R5 R11)
    for (int k = 0; k < NVEC; k++) begin
      logic [4:0] a, b;
      logic [1:0] pa, pb;
      logic [31:0] w0, w1;
      int ex;
      a = VECS[k][19:15]; pa = VECS[k][14:13];
      b = VECS[k][12:8];  pb = VECS[k][7:6];
      ex = int'(VECS[k][5:0]);
      w0 = '0; w1 = '0;
      if (a < 16) w0 |= 32'(pa) << (2 * (a % 16)); else w1 |= 32'(pa) << (2 * (a % 16));
      if (b < 16) w0 |= 32'(pb) << (2 * (b % 16)); else w1 |= 32'(pb) << (2 * (b % 16));
      do_reset();
      cfg(4'd0, (32'd1 << a) | (32'd1 << b));
      cfg(4'd4, w0);
      cfg(4'd5, w1);
      pulse((32'd1 << a) | (32'd1 << b), 5'd0);
      check("R5 R1 R11 table", 1'b1, ex);
    end

    // reset state and latching while disabled
    do_reset();
    check("R10 reset idle", 1'b0, 0);
    pulse(32'd1 << 5, 5'd0);
    check("R10 enables off after reset", 1'b0, 0);
    cfg(4'd0, 32'd0);
    check("R2 zero set-write keeps line off", 1'b0, 0);
    cfg(4'd0, 32'd1 << 5);
    check("R4 latched request offered on enable", 1'b1, 21);
    cfg(4'd1, 32'd0);
    check("R3 zero clear-write keeps line on", 1'b1, 21);
    cfg(4'd1, 32'd1 << 5);
    check("R3 clear-enable hides offer", 1'b0, 0);
    cfg(4'd0, 32'd1 << 5);
    check("R4 pending survives disable", 1'b1, 21);

    // accept, equal-level block, same-cycle re-request
    take();
    check("R8 accept clears pending", 1'b0, 0);
    pulse(32'd1 << 5, 5'd0);
    check("R9 equal level not offered", 1'b0, 0);
    done();
    check("R9 done reopens", 1'b1, 21);
    out_ready = 1; irq_req = 32'd1 << 5; step(); out_ready = 0; irq_req = '0;
    check("R9 re-requested line waits", 1'b0, 0);
    done();
    check("R8 same-cycle request wins", 1'b1, 21);
    take_done();
    check("R8 nothing left", 1'b0, 0);

    // preemption by strictly more urgent level
    cfg(4'd0, (32'd1 << 6) | (32'd1 << 8));
    cfg(4'd4, 32'd1 << 12);               // line 6 prio 1, others 0
    pulse(32'd1 << 6, 5'd0);
    check("R5 single line prio 1", 1'b1, 22);
    take();
    pulse(32'd1 << 8, 5'd0);
    check("R9 more urgent preempts", 1'b1, 24);
    pulse(32'd1 << 5, 5'd0);
    check("R5 tie goes to lower number", 1'b1, 21);
    take();
    check("R9 active prio 0 blocks equal", 1'b0, 0);
    done();
    check("R9 waiting line after done", 1'b1, 24);
    take_done();
    check("R9 queue drained", 1'b0, 0);

    // fixed-priority system exceptions
    pulse(32'd1 << 5, 5'b00111);
    check("R5 NMI first", 1'b1, 2);
    take();
    check("R9 NMI active blocks all", 1'b0, 0);
    done();
    check("R5 HardFault next", 1'b1, 3);
    take_done();
    check("R5 tie svc before line 5", 1'b1, 11);
    take_done();
    check("R5 line 5 last", 1'b1, 21);
    take_done();
    check("R5 all served", 1'b0, 0);

    // system priority fields
    cfg(4'd2, 32'h16);                    // svc 2, deferred 1, tick 1
    pulse('0, 5'b11100);
    check("R11 deferred service wins tie", 1'b1, 14);
    take_done();
    check("R11 tick next", 1'b1, 15);
    take_done();
    check("R11 svc prio 2 last", 1'b1, 11);
    take_done();
    check("R11 drained", 1'b0, 0);

    // block-all mask
    cfg(4'd3, 32'd1);
    pulse(32'd1 << 5, 5'b00100);
    check("R6 programmable blocked", 1'b0, 0);
    pulse('0, 5'b00001);
    check("R6 NMI passes", 1'b1, 2);
    take_done();
    check("R6 still blocked", 1'b0, 0);
    pulse('0, 5'b00010);
    check("R6 HardFault passes", 1'b1, 3);
    take_done();
    cfg(4'd3, 32'd0);
    check("R6 unmasked line 5 first", 1'b1, 21);
    take_done();
    check("R6 then svc", 1'b1, 11);
    take_done();
    check("R6 drained", 1'b0, 0);

    // threshold mask
    cfg(4'd3, 32'd2 << 8);
    cfg(4'd4, (32'd2 << 10) | (32'd1 << 12));   // line 5 prio 2, line 6 prio 1
    pulse(32'd1 << 5, 5'd0);
    check("R7 prio equal to threshold blocked", 1'b0, 0);
    pulse(32'd1 << 6, 5'd0);
    check("R7 prio below threshold passes", 1'b1, 22);
    take_done();
    check("R7 line 5 still blocked", 1'b0, 0);
    cfg(4'd3, 32'd1 << 8);
    check("R7 threshold 1 blocks prio 2", 1'b0, 0);
    pulse('0, 5'b00001);
    check("R7 NMI ignores threshold", 1'b1, 2);
    take_done();
    cfg(4'd3, 32'd3 << 8);
    check("R7 threshold 3 admits prio 2", 1'b1, 21);
    take_done();
    check("R7 drained", 1'b0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule